// File: doc/BRIEF.md
# Multiplexed Bus Target Data-Phase Controller

This block is a simple target on a 32-bit bus that carries address and data on the same wires. All inputs are sampled on the rising clock edge. A transaction opens with an address phase, marked by the active-low frame line falling. On that phase the four command/byte-enable lines hold the bus command, and the address wires hold the start address. One or more data phases follow. During the data phases the same four lines become active-low byte-lane enables.

A data word moves only on a clock where both the initiator-ready and target-ready lines are sampled low. On every other clock the phase waits. The target raises its ready line a programmable number of cycles after the address phase. This lets wait-state behaviour be exercised. Write data is merged lane by lane into a small register bank. Read data is driven back on the bus while target-ready is asserted.

Memory commands step to the next word after each completed phase. I/O commands keep the same word. The transaction ends on the phase that completes while frame is high.

Top module: `bus_tgt_ctrl`

## Requirements
- R1: While rst_n is low, and directly after it is released, trdy_n is 1 and trdy_oe and ad_oe are 0.
- R2: An address phase is a rising edge with frame_n low in the idle state, after frame_n was sampled high on the previous edge. Only four command codes on cbe_n are claimed: 4'b0010 (I/O read), 4'b0011 (I/O write), 4'b0110 (memory read) and 4'b0111 (memory write). Any other code leaves trdy_oe and ad_oe at 0 and writes nothing, until frame_n and irdy_n are both sampled high.
- R3: With wait_cfg = W sampled at the address-phase edge, trdy_n goes low right after the (W+1)-th rising edge that follows the address phase.
- R4: A data phase completes only on an edge where irdy_n and trdy_n are both low. A clock with irdy_n high writes nothing and keeps the word index.
- R5: On a completed write phase, cbe_n[k] = 0 stores ad_in[8k+7:8k] into byte k of the selected word. cbe_n[k] = 1 leaves that byte unchanged.
- R6: For read commands, ad_oe is 1 and ad_out holds the selected word while trdy_n is low. For write commands, ad_oe stays 0.
- R7: For memory commands, the word index starts at address bits [IDX_W+1:2]. It advances by one, modulo 2**IDX_W, after every completed phase.
- R8: For I/O commands, the byte address selects the word by bits [IDX_W+1:2]. Every phase of the burst uses that same word.
- R9: The phase that completes with frame_n high is the last one. After that edge, trdy_n is 1 and trdy_oe and ad_oe are 0.
- R10: Within a burst, trdy_n stays low after each completed non-final phase, so no wait states are added between phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low transaction frame from the initiator |
| irdy_n | input | 1 | Active-low initiator ready |
| cbe_n | input | 4 | Command in the address phase, active-low byte enables in data phases |
| ad_in | input | 32 | Address/data bus as seen by the target |
| wait_cfg | input | WAIT_W | Number of wait cycles before target-ready, sampled at the address phase |
| ad_out | output | 32 | Read data driven onto the bus |
| ad_oe | output | 1 | Drive enable for ad_out |
| trdy_n | output | 1 | Active-low target ready |
| trdy_oe | output | 1 | Drive enable for trdy_n while the target is engaged |

## Verification
The address phase is the reference edge. trdy_n is first seen low at the falling edge W+2 half-cycles-pairs after it, that is on the second falling edge when W is 0. The bench counts falling edges from the address phase and compares that count with W+2.

Completion of a phase is decided from the irdy_n and trdy_n values present just before a rising edge. Read data and ad_oe are therefore checked on the same falling edge where both ready lines are low. The release of trdy_n, trdy_oe and ad_oe after the last phase is checked one falling edge after the completing edge.

Written data is checked later, through memory read bursts, against a bench model that applies the lane enables and the index stepping.

// File: rtl/bus_tgt_pkg.sv
package bus_tgt_pkg;
  localparam int BUS_W = 32;
  localparam int LANES = BUS_W / 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DATA = 2'd2,
    ST_SKIP = 2'd3
  } tgt_state_e;

  // Claimed codes: 0010, 0011, 0110, 0111 (bit3 clear, bit1 set)
  function automatic logic cmd_claimed(input logic [3:0] c);
    return (!c[3]) && c[1];
  endfunction

  function automatic logic cmd_is_write(input logic [3:0] c);
    return c[0];
  endfunction

  function automatic logic cmd_is_mem(input logic [3:0] c);
    return c[2];
  endfunction

  // Merge new lanes into old word under active-low lane enables
  function automatic logic [BUS_W-1:0] merge_lanes(input logic [BUS_W-1:0] old_w,
                                                   input logic [BUS_W-1:0] new_w,
                                                   input logic [LANES-1:0] en_n);
    logic [BUS_W-1:0] r;
    r = old_w;
    for (int k = 0; k < LANES; k++) begin
      if (!en_n[k]) r[8*k +: 8] = new_w[8*k +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/bus_tgt_seq.sv
module bus_tgt_seq
  import bus_tgt_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic [3:0]        cbe_n,
  input  logic [WAIT_W-1:0] wait_cfg,
  output tgt_state_e        state,
  output logic              trdy_n,
  output logic              addr_phase,
  output logic              xfer_done,
  output logic              last_xfer
);
  logic              frame_q;
  logic [WAIT_W-1:0] wait_cnt;

  assign addr_phase = (state == ST_IDLE) && !frame_n && frame_q;
  assign xfer_done  = (state == ST_DATA) && !irdy_n && !trdy_n;
  assign last_xfer  = xfer_done && frame_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= 1'b1;
    else        frame_q <= frame_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      trdy_n   <= 1'b1;
      wait_cnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (addr_phase) begin
            state    <= cmd_claimed(cbe_n) ? ST_WAIT : ST_SKIP;
            wait_cnt <= wait_cfg;
          end
        end
        ST_WAIT: begin
          if (wait_cnt == '0) begin
            state  <= ST_DATA;
            trdy_n <= 1'b0;
          end else begin
            wait_cnt <= wait_cnt - 1'b1;
          end
        end
        ST_DATA: begin
          if (last_xfer) begin
            state  <= ST_IDLE;
            trdy_n <= 1'b1;
          end
        end
        ST_SKIP: begin
          if (frame_n && irdy_n) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bus_tgt_decode.sv
module bus_tgt_decode
  import bus_tgt_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_phase,
  input  logic             xfer_done,
  input  logic [3:0]       cbe_n,
  input  logic [IDX_W-1:0] addr_idx,
  output logic             is_wr,
  output logic             is_mem,
  output logic [IDX_W-1:0] cur_idx
);
  function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] i,
                                                input logic mem);
    return mem ? IDX_W'(i + 1'b1) : i;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_wr   <= 1'b0;
      is_mem  <= 1'b0;
      cur_idx <= '0;
    end else if (addr_phase) begin
      is_wr   <= cmd_is_write(cbe_n);
      is_mem  <= cmd_is_mem(cbe_n);
      cur_idx <= addr_idx;
    end else if (xfer_done) begin
      cur_idx <= step_idx(cur_idx, is_mem);
    end
  end
endmodule

// File: rtl/bus_tgt_regbank.sv
module bus_tgt_regbank
  import bus_tgt_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [LANES-1:0] be_n,
  input  logic [BUS_W-1:0] wr_data,
  output logic [BUS_W-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [BUS_W-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        words[g] <= '0;
      else if (wr_en && (idx == IDX_W'(g)))
        words[g] <= merge_lanes(words[g], wr_data, be_n);
    end
  end

  assign rd_data = words[idx];
endmodule

// File: rtl/bus_tgt_ctrl.sv
module bus_tgt_ctrl
  import bus_tgt_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic [3:0]        cbe_n,
  input  logic [31:0]       ad_in,
  input  logic [WAIT_W-1:0] wait_cfg,
  output logic [31:0]       ad_out,
  output logic              ad_oe,
  output logic              trdy_n,
  output logic              trdy_oe
);
  tgt_state_e       state;
  logic             addr_phase;
  logic             xfer_done;
  logic             last_xfer;
  logic             is_wr;
  logic             is_mem;
  logic [IDX_W-1:0] cur_idx;

  bus_tgt_seq #(.WAIT_W(WAIT_W)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_n    (frame_n),
    .irdy_n     (irdy_n),
    .cbe_n      (cbe_n),
    .wait_cfg   (wait_cfg),
    .state      (state),
    .trdy_n     (trdy_n),
    .addr_phase (addr_phase),
    .xfer_done  (xfer_done),
    .last_xfer  (last_xfer)
  );

  bus_tgt_decode #(.IDX_W(IDX_W)) dec_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_phase (addr_phase),
    .xfer_done  (xfer_done),
    .cbe_n      (cbe_n),
    .addr_idx   (ad_in[IDX_W+1:2]),
    .is_wr      (is_wr),
    .is_mem     (is_mem),
    .cur_idx    (cur_idx)
  );

  bus_tgt_regbank #(.IDX_W(IDX_W)) bank_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (xfer_done && is_wr),
    .idx     (cur_idx),
    .be_n    (cbe_n),
    .wr_data (ad_in),
    .rd_data (ad_out)
  );

  assign trdy_oe = (state == ST_WAIT) || (state == ST_DATA);
  assign ad_oe   = trdy_oe && !is_wr;
endmodule

// File: rtl/bus_tgt_ctrl_chk.sv
module bus_tgt_ctrl_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trdy_n,
  input logic             trdy_oe,
  input logic             ad_oe,
  input logic             addr_phase,
  input logic             xfer_done,
  input logic             last_xfer,
  input logic             is_mem,
  input logic [IDX_W-1:0] cur_idx
);
  AST_QUIET_WHEN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_oe |-> trdy_n) else $error("released target shows ready"); // R9

  AST_READ_DRIVE_ENGAGED: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> trdy_oe) else $error("data driven outside transaction"); // R6

  AST_ADDR_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase |=> trdy_n) else $error("ready too early"); // R3

  AST_INDEX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    trdy_oe && !xfer_done |=> $stable(cur_idx)) else $error("index moved without transfer"); // R4

  AST_MEM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && is_mem && !last_xfer |=> cur_idx == IDX_W'($past(cur_idx) + 1'b1))
    else $error("memory index not stepped"); // R7

  AST_IO_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && !is_mem |=> $stable(cur_idx)) else $error("io index moved"); // R8

  AST_NO_MID_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && !last_xfer |=> !trdy_n) else $error("wait inserted mid burst"); // R10

  AST_LAST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    last_xfer |=> trdy_n && !trdy_oe && !ad_oe) else $error("not released after last"); // R9
endmodule

bind bus_tgt_ctrl bus_tgt_ctrl_chk #(.IDX_W(IDX_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .trdy_n     (trdy_n),
  .trdy_oe    (trdy_oe),
  .ad_oe      (ad_oe),
  .addr_phase (addr_phase),
  .xfer_done  (xfer_done),
  .last_xfer  (last_xfer),
  .is_mem     (is_mem),
  .cur_idx    (cur_idx)
);

// File: tb/bus_tgt_ctrl_tb_top.sv
`timescale 1ns/100ps
module bus_tgt_ctrl_tb_top;
  localparam int IDX_W  = 3;
  localparam int WAIT_W = 4;
  localparam int DEPTH  = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              frame_n, irdy_n;
  logic [3:0]        cbe_n;
  logic [31:0]       ad_in;
  logic [WAIT_W-1:0] wait_cfg;
  logic [31:0]       ad_out;
  logic              ad_oe, trdy_n, trdy_oe;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [DEPTH];
  logic [31:0] ph_data [16];
  logic [3:0]  ph_be [16];

  always #2.5 clk = ~clk;

  bus_tgt_ctrl #(.IDX_W(IDX_W), .WAIT_W(WAIT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .cbe_n(cbe_n), .ad_in(ad_in), .wait_cfg(wait_cfg), .ad_out(ad_out),
    .ad_oe(ad_oe), .trdy_n(trdy_n), .trdy_oe(trdy_oe)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lane_model(input logic [31:0] o, input logic [31:0] n,
                                             input logic [3:0] e);
    logic [31:0] r = o;
    for (int k = 0; k < 4; k++) if (e[k] == 1'b0) r[8*k +: 8] = n[8*k +: 8];
    return r;
  endfunction

  function automatic int word_of(input logic [31:0] a);
    return int'((a >> 2) % DEPTH);
  endfunction

  task automatic run_txn(input logic [3:0] cmd, input logic [31:0] addr, input int nph,
                         input int w, input bit stall, input string tag);
    int idx = word_of(addr);
    bit wr = cmd[0];
    bit mem = cmd[2];
    int negs = 0;
    int first_low = -1;
    bit want_trdy = 0;
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; cbe_n = cmd; ad_in = addr;
    wait_cfg = WAIT_W'(w);
    @(posedge clk);
    for (int p = 0; p < nph; p++) begin
      bit done = 0;
      while (!done) begin
        @(negedge clk);
        negs++;
        if (want_trdy) begin
          check(trdy_n === 1'b0, "R10", {31'd0, trdy_n}, 32'd0);
          want_trdy = 0;
        end
        if (trdy_n === 1'b0 && first_low < 0) first_low = negs;
        cbe_n = ph_be[p];
        ad_in = wr ? ph_data[p] : $urandom;
        irdy_n = (stall && ($urandom % 3 == 0)) ? 1'b1 : 1'b0;
        frame_n = (p == nph - 1 && irdy_n == 1'b0) ? 1'b1 : 1'b0;
        if (trdy_n === 1'b0 && irdy_n == 1'b0) begin
          done = 1;
          if (!wr) check(ad_oe === 1'b1 && ad_out === model[idx], tag, ad_out, model[idx]);
          else     check(ad_oe === 1'b0, "R6", {31'd0, ad_oe}, 32'd0);
          if (wr) model[idx] = lane_model(model[idx], ph_data[p], ph_be[p]);
          if (mem) idx = (idx + 1) % DEPTH;
          if (p != nph - 1) want_trdy = 1;
        end
      end
    end
    check(first_low == w + 2, "R3", first_low, w + 2);
    @(negedge clk);
    check(trdy_n === 1'b1 && trdy_oe === 1'b0 && ad_oe === 1'b0, "R9",
          {29'd0, trdy_n, trdy_oe, ad_oe}, 32'h4);
    frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF;
  endtask

  task automatic read_all(input string tag, input bit stall);
    for (int i = 0; i < DEPTH; i++) ph_be[i] = 4'h0;
    run_txn(4'b0110, 32'h0, DEPTH, 1, stall, tag);
  endtask

  initial begin
    #(5.0 * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    rst_n = 1'b0; frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF; ad_in = '0; wait_cfg = '0;
    repeat (3) @(negedge clk);
    check(trdy_n === 1'b1 && trdy_oe === 1'b0 && ad_oe === 1'b0, "R1",
          {29'd0, trdy_n, trdy_oe, ad_oe}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    check(trdy_n === 1'b1 && trdy_oe === 1'b0 && ad_oe === 1'b0, "R1",
          {29'd0, trdy_n, trdy_oe, ad_oe}, 32'h4);

    // R7: full memory write burst, then readback
    for (int i = 0; i < DEPTH; i++) begin ph_data[i] = 32'hA000_0000 + i * 32'h1111; ph_be[i] = 4'h0; end
    run_txn(4'b0111, 32'h0, DEPTH, 0, 0, "R7");
    read_all("R7", 0);

    // R5: partial byte enables
    ph_data[0] = 32'h1122_3344; ph_be[0] = 4'b1010;
    ph_data[1] = 32'h5566_7788; ph_be[1] = 4'b0111;
    ph_data[2] = 32'h99AA_BBCC; ph_be[2] = 4'b1111;
    run_txn(4'b0111, 32'h8, 3, 2, 0, "R5");
    read_all("R5", 0);

    // R8: I/O burst hits the same word
    ph_data[0] = 32'hDEAD_0000; ph_be[0] = 4'b1100;
    ph_data[1] = 32'h0000_BEEF; ph_be[1] = 4'b0011;
    ph_data[2] = 32'h0042_0000; ph_be[2] = 4'b1011;
    run_txn(4'b0011, 32'h0000_000D, 3, 0, 0, "R8");
    ph_be[0] = 4'h0; ph_be[1] = 4'h0;
    run_txn(4'b0010, 32'h0000_000E, 2, 3, 0, "R8");

    // R7: wrap past the last word
    for (int i = 0; i < 3; i++) begin ph_data[i] = 32'hC0DE_0000 + i; ph_be[i] = 4'h0; end
    run_txn(4'b0111, 32'h18, 3, 1, 0, "R7");
    read_all("R7", 0);

    // R2: unclaimed command writes nothing and stays released
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; cbe_n = 4'b1011; ad_in = 32'h0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(trdy_oe === 1'b0 && ad_oe === 1'b0, "R2", {30'd0, trdy_oe, ad_oe}, 32'd0);
      cbe_n = 4'h0; ad_in = 32'hFFFF_FFFF; irdy_n = 1'b0; frame_n = (i >= 3) ? 1'b1 : 1'b0;
    end
    @(negedge clk);
    frame_n = 1'b1; irdy_n = 1'b1;
    read_all("R2", 0);

    // R4: random traffic with initiator stalls
    for (int t = 0; t < 30; t++) begin
      logic [3:0] cmd;
      int n;
      case ($urandom % 4)
        0: cmd = 4'b0010; 1: cmd = 4'b0011; 2: cmd = 4'b0110; default: cmd = 4'b0111;
      endcase
      n = 1 + int'($urandom % 5);
      for (int i = 0; i < n; i++) begin ph_data[i] = $urandom; ph_be[i] = 4'($urandom); end
      run_txn(cmd, $urandom, n, int'($urandom % 4), 1, "R4");
    end
    read_all("R4", 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule